// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that counts on its own slow tick, which comes in as a one-cycle enable on the block clock. A power-of-two prescaler divides the tick. The result clocks a 12-bit down-counter. When the counter runs out, the block emits a one-cycle reset request. Software talks to the block through a small word-addressed register port. A key register takes three magic values. One opens the configuration registers for writing, one starts the dog, and one refreshes the counter. Any other value written there closes the configuration registers again.

Prescaler and reload values are written into staging registers. Each write then passes to the counting side after a fixed number of slow ticks. A busy flag per register shows that the transfer is still in flight. An optional early-warning compare raises a one-cycle interrupt as the count falls to a programmed value, before the reset request. The dog has two states, Stopped and Running. Enable moves it from Stopped to Running. No write leads back, and only the block reset returns it to Stopped. The lock has two states, Shut and Open. The unlock key moves Shut to Open, and every other key write moves either state to Shut. Each transfer channel has two states, Idle and Pending. An accepted write moves Idle or Pending to Pending and restarts the count. The last transfer tick moves Pending back to Idle.

Top module: `wdg_top`

## Requirements
- R1: After reset the dog is Stopped and the lock is Shut. Readback then gives prescaler 0 at address 1, reload 0xFFF at address 2, early compare 0 at address 3, and status 0 at address 4. Address 0 always reads 0.
- R2: Writing 0x5555 to the key register (address 0) opens the lock. Writes to addresses 1, 2 and 3 are ignored while it is Shut. A key write of any other value shuts it.
- R3: Writing 0xCCCC to the key register starts the dog. Before that, ticks produce no reset request.
- R4: Writing 0xAAAA to the key register while Running reloads the counter from the active reload value and clears the prescaler phase.
- R5: Prescaler code c (bits 3:0 of address 1) divides the tick by 2^(2+c). Codes above the variant maximum saturate to the largest divider, which is 256 by default and 1024 in the other variant.
- R6: With active reload R and divider D, rst_req pulses for one cycle on the (R+1)*D-th tick after a start or a refresh. The counter then restarts from R.
- R7: Once Running, no key value and no register write stops the count. Only rst_n returns the block to Stopped.
- R8: Address 3 holds a compare value C in bits 11:0 and an enable in bit 15. When the enable is set, early_irq pulses for one cycle as the count falls to C, which is on tick (R-C)*D after a refresh. If C >= R it never fires. When the enable is clear it never fires.
- R9: Status bit 0 (prescaler) and bit 1 (reload) set on an accepted write to their register. Each clears on the third following tick (BUSY_TICKS), and a rewrite restarts that count.
- R10: A new prescaler or reload value takes effect only when its busy bit clears. A refresh issued while the value is still Pending uses the old value.
- R11: Without a tick the count and prescaler hold, and neither output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable from the slow watchdog oscillator |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| rst_req | output | 1 | One-cycle reset request on expiry |
| early_irq | output | 1 | One-cycle early-warning interrupt |

## Verification
The hardest situation to reach from the ports is a refresh that lands while a reload transfer is still Pending. In that case the first expiry must use the old value and the expiry after the wrap must use the new one. The stimulus reaches it by writing the reload register and then, before any tick passes, writing the refresh key. It then counts ticks to both pulses. Randomised trials draw reload, prescaler code and compare settings from a seeded generator. Directed cases cover prescaler saturation, a refresh in the middle of a prescaler period, compare values at or above the reload, and foreign key writes during a run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [DATA_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_FEED   = 16'hAAAA;

    localparam logic [ADDR_W-1:0] A_KEY  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD  = 3'd2;
    localparam logic [ADDR_W-1:0] A_EWC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    localparam int EWC_EN_BIT = 15;

    typedef enum logic {LK_SHUT, LK_OPEN} lock_st_t;
    typedef enum logic {XS_IDLE, XS_PEND} xfer_st_t;
    typedef enum logic {CS_STOP, CS_RUN} core_st_t;
endpackage

// File: rtl/wdg_regfile.sv
module wdg_regfile
    import wdg_pkg::*;
#(
    parameter int RLD_W    = 12,
    parameter int PRE_W    = 4,
    parameter bit HAS_EARLY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy_pre,
    input  logic              busy_rld,
    output logic              unlocked,
    output logic [PRE_W-1:0]  pre_q,
    output logic [RLD_W-1:0]  rld_q,
    output logic [RLD_W-1:0]  ewc_val,
    output logic              ewc_en,
    output logic              pre_wr,
    output logic              rld_wr,
    output logic              start_key,
    output logic              feed_key,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [RLD_W-1:0] RLD_RESET = '1;

    lock_st_t lk_q, lk_d;
    logic     key_wr;
    logic     ewc_wr;

    assign key_wr    = wr_en && (addr == A_KEY);
    assign unlocked  = (lk_q == LK_OPEN);
    assign pre_wr    = wr_en && (addr == A_PRE) && unlocked;
    assign rld_wr    = wr_en && (addr == A_RLD) && unlocked;
    assign ewc_wr    = wr_en && (addr == A_EWC) && unlocked;
    assign start_key = key_wr && (wdata == KEY_START);
    assign feed_key  = key_wr && (wdata == KEY_FEED);

    // lock state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_SHUT;
        else        lk_q <= lk_d;
    end

    // lock transitions: unlock key opens, any other key shuts
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_SHUT: if (key_wr && wdata == KEY_UNLOCK) lk_d = LK_OPEN;
            LK_OPEN: if (key_wr && wdata != KEY_UNLOCK) lk_d = LK_SHUT;
            default: lk_d = LK_SHUT;
        endcase
    end

    // staged configuration values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            rld_q <= RLD_RESET;
        end else begin
            if (pre_wr) pre_q <= wdata[PRE_W-1:0];
            if (rld_wr) rld_q <= wdata[RLD_W-1:0];
        end
    end

    generate
        if (HAS_EARLY) begin : g_early
            logic [RLD_W-1:0] cmp_q;
            logic             cmp_en_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cmp_q    <= '0;
                    cmp_en_q <= 1'b0;
                end else if (ewc_wr) begin
                    cmp_q    <= wdata[RLD_W-1:0];
                    cmp_en_q <= wdata[EWC_EN_BIT];
                end
            end
            assign ewc_val = cmp_q;
            assign ewc_en  = cmp_en_q;
        end else begin : g_no_early
            assign ewc_val = '0;
            assign ewc_en  = 1'b0;
        end
    endgenerate

    // readback
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_PRE:  rdata[PRE_W-1:0] = pre_q;
            A_RLD:  rdata[RLD_W-1:0] = rld_q;
            A_EWC: begin
                rdata[RLD_W-1:0]  = ewc_val;
                rdata[EWC_EN_BIT] = ewc_en;
            end
            A_STAT: rdata[1:0] = {busy_rld, busy_pre};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdg_xfer.sv
module wdg_xfer
    import wdg_pkg::*;
#(
    parameter int             W          = 12,
    parameter logic [W-1:0]   RST_VAL    = '0,
    parameter int             BUSY_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic [W-1:0] dout
);
    localparam int CNT_W = (BUSY_TICKS < 2) ? 1 : $clog2(BUSY_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_TICKS - 1);

    xfer_st_t          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              done;

    assign done = (st_q == XS_PEND) && tick && (cnt_q == LAST) && !load;
    assign busy = (st_q == XS_PEND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= XS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XS_IDLE: if (load) st_d = XS_PEND;
            XS_PEND: if (done) st_d = XS_IDLE;
            default: st_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dout  <= RST_VAL;
        end else begin
            if (load)                           cnt_q <= '0;
            else if (st_q == XS_PEND && tick)   cnt_q <= cnt_q + 1'b1;
            if (done)                           dout  <= din;
        end
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int RLD_W        = 12,
    parameter int PRE_W        = 4,
    parameter int BASE_SHIFT   = 2,
    parameter int MAX_DIV_LOG2 = 8,
    parameter bit HAS_EARLY    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             feed,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [RLD_W-1:0] rld_val,
    input  logic [RLD_W-1:0] ewc_val,
    input  logic             ewc_en,
    output logic             running,
    output logic             rst_req,
    output logic             early_irq
);
    localparam int PCNT_W   = MAX_DIV_LOG2;
    localparam int MAX_CODE = MAX_DIV_LOG2 - BASE_SHIFT;
    localparam logic [PRE_W-1:0] MAX_CODE_V = PRE_W'(MAX_CODE);

    core_st_t          st_q, st_d;
    logic [RLD_W-1:0]  cnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [PRE_W-1:0]  code_sat;
    logic [PCNT_W-1:0] div_m1;
    logic              ptick;
    logic [RLD_W-1:0]  cnt_dec;
    logic              hit_cmp;

    assign code_sat = (pre_code > MAX_CODE_V) ? MAX_CODE_V : pre_code;
    assign div_m1   = PCNT_W'((32'd1 << (32'(code_sat) + BASE_SHIFT)) - 32'd1);
    assign ptick    = tick && (pcnt_q == div_m1);
    assign cnt_dec  = cnt_q - 1'b1;
    assign hit_cmp  = HAS_EARLY && ewc_en && (cnt_q != '0) && (cnt_dec == ewc_val);
    assign running  = (st_q == CS_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CS_STOP;
        else        st_q <= st_d;
    end

    // transitions: start is the only way in, nothing leads out
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CS_STOP: if (start) st_d = CS_RUN;
            CS_RUN:  st_d = CS_RUN;
            default: st_d = CS_STOP;
        endcase
    end

    // counting datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pcnt_q    <= '0;
            rst_req   <= 1'b0;
            early_irq <= 1'b0;
        end else begin
            rst_req   <= 1'b0;
            early_irq <= 1'b0;
            unique case (st_q)
                CS_STOP: begin
                    if (start) begin
                        cnt_q  <= rld_val;
                        pcnt_q <= '0;
                    end
                end
                CS_RUN: begin
                    if (start || feed) begin
                        cnt_q  <= rld_val;
                        pcnt_q <= '0;
                    end else if (ptick) begin
                        pcnt_q <= '0;
                        if (cnt_q == '0) begin
                            rst_req <= 1'b1;
                            cnt_q   <= rld_val;
                        end else begin
                            cnt_q     <= cnt_dec;
                            early_irq <= hit_cmp;
                        end
                    end else if (tick) begin
                        pcnt_q <= pcnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int RLD_W        = 12,
    parameter int PRE_W        = 4,
    parameter int BASE_SHIFT   = 2,
    parameter int MAX_DIV_LOG2 = 8,
    parameter bit HAS_EARLY    = 1'b1,
    parameter int BUSY_TICKS   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rst_req,
    output logic              early_irq
);
    localparam logic [RLD_W-1:0] RLD_INIT = '1;
    localparam logic [PRE_W-1:0] PRE_INIT = '0;

    logic             unlocked;
    logic [PRE_W-1:0] pre_q, pre_act;
    logic [RLD_W-1:0] rld_q, rld_act;
    logic [RLD_W-1:0] ewc_val;
    logic             ewc_en;
    logic             pre_wr, rld_wr;
    logic             start_key, feed_key;
    logic             busy_pre, busy_rld;
    logic             running;

    wdg_regfile #(.RLD_W(RLD_W), .PRE_W(PRE_W), .HAS_EARLY(HAS_EARLY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy_pre(busy_pre), .busy_rld(busy_rld), .unlocked(unlocked),
        .pre_q(pre_q), .rld_q(rld_q), .ewc_val(ewc_val), .ewc_en(ewc_en),
        .pre_wr(pre_wr), .rld_wr(rld_wr), .start_key(start_key),
        .feed_key(feed_key), .rdata(rdata)
    );

    wdg_xfer #(.W(PRE_W), .RST_VAL(PRE_INIT), .BUSY_TICKS(BUSY_TICKS)) u_xfer_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(pre_wr), .din(pre_q),
        .busy(busy_pre), .dout(pre_act)
    );

    wdg_xfer #(.W(RLD_W), .RST_VAL(RLD_INIT), .BUSY_TICKS(BUSY_TICKS)) u_xfer_rld (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(rld_wr), .din(rld_q),
        .busy(busy_rld), .dout(rld_act)
    );

    wdg_core #(.RLD_W(RLD_W), .PRE_W(PRE_W), .BASE_SHIFT(BASE_SHIFT),
               .MAX_DIV_LOG2(MAX_DIV_LOG2), .HAS_EARLY(HAS_EARLY)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_key), .feed(feed_key),
        .pre_code(pre_act), .rld_val(rld_act), .ewc_val(ewc_val), .ewc_en(ewc_en),
        .running(running), .rst_req(rst_req), .early_irq(early_irq)
    );
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
    import wdg_pkg::*;
#(
    parameter int PRE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [15:0]      wdata,
    input logic             rst_req,
    input logic             early_irq,
    input logic             running,
    input logic             unlocked,
    input logic             busy_pre,
    input logic [PRE_W-1:0] pre_q,
    input logic             ewc_en
);
    a_r2_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PRE && !unlocked) |=> $stable(pre_q));

    a_r2_foreign_key_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wdata != KEY_UNLOCK) |=> !unlocked);

    a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_KEY && wdata == KEY_START) |=> running);

    a_r7_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> $past(ewc_en));

    a_r8_irq_apart_from_rst: assert property (@(posedge clk) disable iff (!rst_n)
        early_irq |-> !rst_req);

    a_r9_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PRE && unlocked) |=> busy_pre);

    a_r11_no_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!rst_req && !early_irq));
endmodule

bind wdg_top wdg_chk #(.PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rst_req(rst_req), .early_irq(early_irq), .running(running),
    .unlocked(unlocked), .busy_pre(busy_pre), .pre_q(pre_q), .ewc_en(ewc_en)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_req, early_irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    wdg_top dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
                 .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .early_irq(early_irq));

    always #(CLK_P/2) clk = ~clk;

    function automatic int divider(input int code);
        int c;
        c = (code > 6) ? 6 : code;
        return 1 << (2 + c);
    endfunction

    function automatic int rst_tick(input int r, input int code);
        return (r + 1) * divider(code);
    endfunction

    function automatic int irq_tick(input int r, input int c, input bit en, input int code);
        if (!en || c >= r) return 0;
        return (r - c) * divider(code);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        @(negedge clk);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic tick1(output bit r, output bit e);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        r = rst_req; e = early_irq;
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        bit r, e;
        for (int i = 0; i < n; i++) tick1(r, e);
    endtask

    // tick until rst_req or lim; first irq before it
    task automatic run_until(input int lim, output int rst_at, output int irq_at);
        bit r, e;
        rst_at = 0; irq_at = 0;
        for (int i = 1; i <= lim; i++) begin
            tick1(r, e);
            if (e && irq_at == 0) irq_at = i;
            if (r) begin rst_at = i; break; end
        end
    endtask

    task automatic setup(input int code, input int r, input int c, input bit en);
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'(code));
        wr(3'd2, 16'(r));
        wr(3'd3, {en, 3'b000, 12'(c)});
        ticks(3);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int d, ra, ia;
        bit r, e, quiet;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, d); check(d == 0, "R1 prescaler reset", d, 0);
        rd(3'd2, d); check(d == 12'hFFF, "R1 reload reset", d, 12'hFFF);
        rd(3'd3, d); check(d == 0, "R1 compare reset", d, 0);
        rd(3'd4, d); check(d == 0, "R1 status reset", d, 0);
        rd(3'd0, d); check(d == 0, "R1 key reads zero", d, 0);

        // R2 locked write ignored
        wr(3'd1, 16'h0003);
        rd(3'd1, d); check(d == 0, "R2 locked prescaler write", d, 0);
        rd(3'd4, d); check(d == 0, "R2 locked write no busy", d, 0);

        // R2 unlock, R9 busy set
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'h0001);
        rd(3'd1, d); check(d == 1, "R2 unlocked write", d, 1);
        rd(3'd4, d); check(d == 1, "R9 prescaler busy set", d, 1);
        wr(3'd0, 16'h1234);
        wr(3'd2, 16'h0005);
        rd(3'd2, d); check(d == 12'hFFF, "R2 foreign key relocks", d, 12'hFFF);

        // R9 busy clears on third tick
        ticks(2);
        rd(3'd4, d); check(d == 1, "R9 busy after two ticks", d, 1);
        ticks(1);
        rd(3'd4, d); check(d == 0, "R9 busy clear after three", d, 0);

        // R9 rewrite restarts
        wr(3'd0, 16'h5555);
        wr(3'd1, 16'h0001);
        ticks(2);
        wr(3'd1, 16'h0001);
        ticks(2);
        rd(3'd4, d); check(d == 1, "R9 rewrite restarts count", d, 1);
        ticks(1);
        rd(3'd4, d); check(d == 0, "R9 rewrite then clear", d, 0);

        // R3 stopped: no request
        setup(1, 3, 1, 1'b1);
        run_until(100, ra, ia);
        check(ra == 0, "R3 no request while stopped", ra, 0);

        // R3 R6 R8 start
        wr(3'd0, 16'hCCCC);
        run_until(200, ra, ia);
        check(ra == rst_tick(3, 1), "R6 first expiry", ra, rst_tick(3, 1));
        check(ia == irq_tick(3, 1, 1, 1), "R8 early warning", ia, irq_tick(3, 1, 1, 1));
        run_until(200, ra, ia);
        check(ra == rst_tick(3, 1), "R6 wrap expiry", ra, rst_tick(3, 1));
        check(ia == irq_tick(3, 1, 1, 1), "R8 early after wrap", ia, irq_tick(3, 1, 1, 1));

        // R11 no tick, nothing moves
        quiet = 1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rst_req || early_irq) quiet = 0;
        end
        check(quiet, "R11 quiet without ticks", int'(!quiet), 0);
        run_until(200, ra, ia);
        check(ra == rst_tick(3, 1), "R11 count held across gap", ra, rst_tick(3, 1));

        // R7 foreign keys and writes do not stop
        wr(3'd0, 16'hAAAA);
        ticks(10);
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'hFFFF);
        wr(3'd0, 16'h5555);
        wr(3'd0, 16'h1111);
        run_until(200, ra, ia);
        check(ra == rst_tick(3, 1) - 10, "R7 keeps running", ra, rst_tick(3, 1) - 10);

        // R10 refresh while reload pending
        wr(3'd0, 16'h5555);
        wr(3'd2, 16'd10);
        wr(3'd0, 16'hAAAA);
        run_until(300, ra, ia);
        check(ra == rst_tick(3, 1), "R10 old reload used", ra, rst_tick(3, 1));
        run_until(300, ra, ia);
        check(ra == rst_tick(10, 1), "R10 new reload after wrap", ra, rst_tick(10, 1));

        // R5 saturation
        setup(15, 0, 0, 1'b0);
        wr(3'd0, 16'hAAAA);
        run_until(600, ra, ia);
        check(ra == 256, "R5 code saturates at 256", ra, 256);
        check(ia == 0, "R8 disabled compare", ia, 0);

        // R4 refresh mid prescaler period
        setup(0, 2, 0, 1'b0);
        wr(3'd0, 16'hAAAA);
        ticks(7);
        wr(3'd0, 16'hAAAA);
        run_until(100, ra, ia);
        check(ra == rst_tick(2, 0), "R4 refresh restarts", ra, rst_tick(2, 0));

        // R8 compare at reload never fires
        setup(0, 2, 2, 1'b1);
        wr(3'd0, 16'hAAAA);
        run_until(100, ra, ia);
        check(ia == 0, "R8 compare equal reload silent", ia, 0);
        check(ra == rst_tick(2, 0), "R6 expiry div4", ra, rst_tick(2, 0));

        // random trials
        for (int t = 0; t < 10; t++) begin
            int rr, cc, cd;
            bit en;
            rr = int'($urandom_range(15, 0));
            cc = int'($urandom_range(15, 0));
            cd = int'($urandom_range(2, 0));
            en = 1'($urandom_range(1, 0));
            setup(cd, rr, cc, en);
            wr(3'd0, 16'hAAAA);
            run_until(rst_tick(rr, cd) + 5, ra, ia);
            check(ra == rst_tick(rr, cd), "R6 random expiry", ra, rst_tick(rr, cd));
            check(ia == irq_tick(rr, cc, en, cd), "R8 random early", ia, irq_tick(rr, cc, en, cd));
        end

        // R7 only reset stops; R1 after reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        run_until(200, ra, ia);
        check(ra == 0, "R7 reset stops the dog", ra, 0);
        rd(3'd2, d); check(d == 12'hFFF, "R1 reload after reset", d, 12'hFFF);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule